// File: doc/BRIEF.md
# Bus Access Timeout Watchdog

This block guards every bus transfer forwarded to a slow memory. When the memory sequencer begins an access, the watchdog starts timing it. If the memory raises its completion strobe in time, nothing happens. If the access runs too long, the watchdog ends the bus transfer with a two-cycle error response, tells the memory sequencer to abandon the access, raises a timeout flag and posts an interrupt.

The allowed time is held in an 8-bit limit register. Time is counted in steps of a fixed 128-cycle prescaler, so a limit value N allows (N+1)×128 clock cycles. A limit of zero turns the watchdog off. The limit is captured when an access starts, so software may rewrite it at any time without disturbing the access that is already being timed. An interrupt enable bit gates the interrupt output. The pending interrupt stays set until a clear pulse arrives.

Top module: `bus_timeout_watchdog`

## Requirements
- R1: With a captured limit N other than 0, the error response begins exactly (N+1)×128 rising clock edges after the edge that samples `acc_start_i`, provided `acc_done_i` is not sampled high before then.
- R2: With a captured limit of 0, no error response, timeout flag or interrupt is ever produced, however long the access lasts.
- R3: The limit is captured on the edge that accepts a start. A limit written while an access is in progress applies only from the next access.
- R4: The error response lasts two cycles: first `hresp_o`=1 with `hready_o`=0 and `abort_o`=1, then `hresp_o`=1 with `hready_o`=1 and `abort_o`=0. After that the block is idle with `hresp_o`=0 and `hready_o`=1. `hready_o` is 0 while an access is being timed.
- R5: `acc_done_i` sampled high while an access is timed ends it without error. This holds on the very edge on which the limit would otherwise expire.
- R6: A start sampled while an access is being timed restarts the count from zero and captures the limit again.
- R7: `timeout_o` goes to 1 on the edge that begins an error response. It stays at 1 until the next accepted start.
- R8: An expiry sets a pending interrupt. It stays set until `irq_clr_i` is sampled high. If an expiry and a clear fall on the same edge, the expiry wins.
- R9: `irq_o` equals the pending interrupt ANDed with the enable bit. A change of the enable bit takes effect on the edge of its write.
- R10: After reset the limit is 0x40, the interrupt enable is 1, `hresp_o`=0, `hready_o`=1, and `abort_o`, `timeout_o` and `irq_o` are all 0.
- R11: A start sampled during either cycle of the error response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start_i | input | 1 | Memory access begins (one-cycle strobe) |
| acc_done_i | input | 1 | Memory access finished (one-cycle strobe) |
| cfg_we_i | input | 1 | Write strobe for the limit and enable register |
| cfg_limit_i | input | 8 | New timeout limit, in 128-cycle steps (0 = off) |
| cfg_irq_en_i | input | 1 | New interrupt enable value |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the pending interrupt |
| hresp_o | output | 1 | Bus error response from the watchdog |
| hready_o | output | 1 | Bus ready term from the watchdog (0 while timing, 0 in the first error cycle) |
| abort_o | output | 1 | Tells the memory sequencer to abandon the access |
| timeout_o | output | 1 | Last access ended by timeout |
| irq_o | output | 1 | Interrupt request, gated by the enable bit |

## Verification
The assertions assume that `acc_start_i` and `acc_done_i` are single-cycle strobes from a sequencer that starts at most one access at a time. They also assume that `acc_done_i` refers to the access currently being timed. The stimulus raises each strobe at a falling edge for exactly one cycle. It never raises a done strobe outside an access it began. It crosses an error response with a start only in the scenario that checks the start is ignored.

// File: rtl/wd_pkg.sv
// Package: shared types for the bus access timeout watchdog.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package wd_pkg;
    // Sequencing states of the watchdog control path
    typedef enum logic [1:0] {
        WD_IDLE     = 2'd0,
        WD_BUSY     = 2'd1,
        WD_ERR_HOLD = 2'd2,
        WD_ERR_DONE = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wd_cfg_reg.sv
// Holds the timeout limit and the interrupt enable written by software.
// Assumes a single write strobe updating both fields at once.
module wd_cfg_reg #(
    parameter int          LIMIT_W     = 8,
    parameter logic [LIMIT_W-1:0] RESET_LIMIT = 8'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [LIMIT_W-1:0] limit_d,
    input  logic               irq_en_d,
    output logic [LIMIT_W-1:0] limit_q,
    output logic               irq_en_q
);
    // Register update with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q  <= RESET_LIMIT;
            irq_en_q <= 1'b1;
        end else if (we_i) begin
            limit_q  <= limit_d;
            irq_en_q <= irq_en_d;
        end
    end
endmodule

// File: rtl/wd_prescaler.sv
// Divides the bus clock into steps of PRESCALE cycles while an access is timed.
// Assumes clear_i is asserted on the edge that accepts a new access.
module wd_prescaler #(
    parameter int PRESCALE = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_q;

    // Tick on the last cycle of each prescale step
    assign tick_o = run_i && (cnt_q == LAST);

    // Cycle count within the current step
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clear_i && cnt_q == LAST) |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/wd_span_counter.sv
// Counts prescale steps against the limit captured at access start.
// Assumes load_i marks the accepting edge and tick_i comes from the prescaler.
module wd_span_counter #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               run_i,
    input  logic               tick_i,
    output logic               expire_o,
    output logic               disabled_o
);
    logic [LIMIT_W-1:0] lim_q;
    logic [LIMIT_W-1:0] steps_q;

    // A zero captured limit switches the watchdog off for this access
    assign disabled_o = (lim_q == '0);
    // Expiry on the tick that completes step number lim_q+1
    assign expire_o   = run_i && tick_i && !disabled_o && (steps_q == lim_q);

    // Capture limit at start, count whole steps while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q   <= '0;
            steps_q <= '0;
        end else if (load_i) begin
            lim_q   <= limit_i;
            steps_q <= '0;
        end else if (run_i && tick_i && steps_q != lim_q) begin
            steps_q <= steps_q + 1'b1;
        end
    end

    AST_STEPS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !disabled_o) |-> (steps_q <= lim_q)); // R1
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(lim_q)); // R3
endmodule

// File: rtl/bus_timeout_watchdog.sv
// Top: times each memory access and ends a late one with a bus error response.
// Assumes single-cycle start/done strobes and one access outstanding at a time.
module bus_timeout_watchdog #(
    parameter int                 LIMIT_W     = 8,
    parameter int                 PRESCALE    = 128,
    parameter logic [LIMIT_W-1:0] RESET_LIMIT = 8'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_start_i,
    input  logic               acc_done_i,
    input  logic               cfg_we_i,
    input  logic [LIMIT_W-1:0] cfg_limit_i,
    input  logic               cfg_irq_en_i,
    input  logic               irq_clr_i,
    output logic               hresp_o,
    output logic               hready_o,
    output logic               abort_o,
    output logic               timeout_o,
    output logic               irq_o
);
    import wd_pkg::*;

    wd_state_t          state_q, state_d;
    logic [LIMIT_W-1:0] limit_q;
    logic               irq_en_q;
    logic               busy, load, tick, expire, disabled, expire_go;
    logic               irq_pend_q;

    wd_cfg_reg #(.LIMIT_W(LIMIT_W), .RESET_LIMIT(RESET_LIMIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .limit_d(cfg_limit_i),
        .irq_en_d(cfg_irq_en_i), .limit_q(limit_q), .irq_en_q(irq_en_q)
    );

    // Starts are accepted only outside the error response
    assign busy = (state_q == WD_BUSY);
    assign load = acc_start_i && (state_q == WD_IDLE || busy);

    wd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear_i(load), .run_i(busy), .tick_o(tick)
    );

    wd_span_counter #(.LIMIT_W(LIMIT_W)) u_span (
        .clk(clk), .rst_n(rst_n), .load_i(load), .limit_i(limit_q),
        .run_i(busy), .tick_i(tick), .expire_o(expire), .disabled_o(disabled)
    );

    // Expiry counts only when neither completion nor restart arrives
    assign expire_go = busy && expire && !acc_done_i && !acc_start_i;

    // Next-state selection: restart, completion, expiry, error sequencing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:     if (acc_start_i) state_d = WD_BUSY;
            WD_BUSY: begin
                if (acc_start_i)     state_d = WD_BUSY;
                else if (acc_done_i) state_d = WD_IDLE;
                else if (expire)     state_d = WD_ERR_HOLD;
            end
            WD_ERR_HOLD: state_d = WD_ERR_DONE;
            WD_ERR_DONE: state_d = WD_IDLE;
            default:     state_d = WD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    // Timeout flag: set on expiry, cleared by the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)         timeout_o <= 1'b0;
        else if (expire_go) timeout_o <= 1'b1;
        else if (load)      timeout_o <= 1'b0;
    end

    // Pending interrupt: expiry wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_pend_q <= 1'b0;
        else if (expire_go) irq_pend_q <= 1'b1;
        else if (irq_clr_i) irq_pend_q <= 1'b0;
    end

    // Bus response and sequencer abort decoded from state
    assign hresp_o  = (state_q == WD_ERR_HOLD) || (state_q == WD_ERR_DONE);
    assign hready_o = (state_q == WD_IDLE) || (state_q == WD_ERR_DONE);
    assign abort_o  = (state_q == WD_ERR_HOLD);
    assign irq_o    = irq_pend_q && irq_en_q;

    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && !hready_o) |=> (hresp_o && hready_o && !abort_o)); // R4
    AST_ERR_END: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && hready_o) |=> (!hresp_o && hready_o)); // R4
    AST_ERR_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hresp_o) |-> ($past(busy) && timeout_o)); // R7
    AST_OFF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && disabled && !acc_start_i) |=> !hresp_o); // R2
    AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc_done_i && !acc_start_i) |=> (hready_o && !hresp_o)); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_q && !irq_clr_i) |=> irq_pend_q); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && hready_o) |=> (state_q == WD_IDLE)); // R11
endmodule

// File: tb/test_bus_timeout_watchdog.sv
module test_bus_timeout_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start_i = 1'b0, acc_done_i = 1'b0;
    logic       cfg_we_i = 1'b0, cfg_irq_en_i = 1'b1, irq_clr_i = 1'b0;
    logic [7:0] cfg_limit_i = 8'h40;
    logic       hresp_o, hready_o, abort_o, timeout_o, irq_o;
    int         n_chk = 0, n_fail = 0;
    logic       done_flag = 1'b0;

    always #2.5 clk = ~clk;

    bus_timeout_watchdog i_bus_timeout_watchdog (
        .clk(clk), .rst_n(rst_n), .acc_start_i(acc_start_i), .acc_done_i(acc_done_i),
        .cfg_we_i(cfg_we_i), .cfg_limit_i(cfg_limit_i), .cfg_irq_en_i(cfg_irq_en_i),
        .irq_clr_i(irq_clr_i), .hresp_o(hresp_o), .hready_o(hready_o),
        .abort_o(abort_o), .timeout_o(timeout_o), .irq_o(irq_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Single-edge strobes, driven at the falling edge
    task automatic start_acc();
        acc_start_i = 1'b1; @(negedge clk); acc_start_i = 1'b0;
    endtask
    task automatic done_acc();
        acc_done_i = 1'b1; @(negedge clk); acc_done_i = 1'b0;
    endtask
    task automatic cfg_write(input logic [7:0] lim, input logic en);
        cfg_we_i = 1'b1; cfg_limit_i = lim; cfg_irq_en_i = en;
        @(negedge clk); cfg_we_i = 1'b0;
    endtask
    task automatic irq_clear();
        irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
    endtask

    // Expect the error response t edges after the start edge
    task automatic expect_expiry(input int t, input string req);
        repeat (t - 1) @(negedge clk);
        chk(!hresp_o && !hready_o, req, hresp_o, 0);
        @(negedge clk);
        chk(hresp_o && !hready_o && abort_o, req, {hresp_o, hready_o, abort_o}, 3'b101);
        @(negedge clk);
        chk(hresp_o && hready_o && !abort_o, "R4", {hresp_o, hready_o, abort_o}, 3'b110);
        @(negedge clk);
        chk(!hresp_o && hready_o, "R4", {hresp_o, hready_o}, 2'b01);
    endtask

    task automatic t_reset();
        chk(!hresp_o && hready_o && !abort_o && !timeout_o && !irq_o, "R10",
            {hresp_o, hready_o, abort_o, timeout_o, irq_o}, 5'b01000);
    endtask

    task automatic t_default_limit();
        start_acc();
        expect_expiry(65 * 128, "R10");
        chk(timeout_o == 1'b1, "R7", timeout_o, 1);
        chk(irq_o == 1'b1, "R8", irq_o, 1);
        repeat (20) @(negedge clk);
        chk(irq_o == 1'b1, "R8", irq_o, 1);
        irq_clear();
        chk(irq_o == 1'b0, "R8", irq_o, 0);
        chk(timeout_o == 1'b1, "R7", timeout_o, 1);
    endtask

    task automatic t_short_limit();
        cfg_write(8'd1, 1'b1);
        start_acc();
        chk(timeout_o == 1'b0, "R7", timeout_o, 0);
        expect_expiry(256, "R1");
        irq_clear();
    endtask

    task automatic t_done_early();
        start_acc();
        repeat (99) @(negedge clk);
        done_acc();
        chk(!hresp_o && hready_o, "R5", hready_o, 1);
        repeat (300) @(negedge clk);
        chk(!hresp_o && !timeout_o && !irq_o, "R5", {hresp_o, timeout_o, irq_o}, 0);
    endtask

    task automatic t_done_on_expiry();
        start_acc();
        repeat (255) @(negedge clk);
        done_acc();
        chk(!hresp_o && hready_o && !timeout_o, "R5", {hresp_o, hready_o, timeout_o}, 3'b010);
        repeat (5) @(negedge clk);
        chk(!irq_o && !hresp_o, "R5", irq_o, 0);
    endtask

    task automatic t_zero_off();
        int seen = 0;
        cfg_write(8'd0, 1'b1);
        start_acc();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (hresp_o || timeout_o || irq_o || hready_o) seen++;
        end
        chk(seen == 0, "R2", seen, 0);
        done_acc();
        chk(hready_o == 1'b1, "R2", hready_o, 1);
    endtask

    task automatic t_mid_change();
        int seen = 0;
        cfg_write(8'd1, 1'b1);
        start_acc();
        repeat (10) @(negedge clk);
        cfg_write(8'd0, 1'b1);
        expect_expiry(256 - 11, "R3");
        irq_clear();
        start_acc();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (hresp_o) seen++;
        end
        chk(seen == 0, "R3", seen, 0);
        done_acc();
    endtask

    task automatic t_restart();
        cfg_write(8'd1, 1'b1);
        start_acc();
        repeat (200) @(negedge clk);
        start_acc();
        expect_expiry(256, "R6");
    endtask

    task automatic t_irq_gate();
        chk(irq_o == 1'b1, "R9", irq_o, 1);
        cfg_write(8'd1, 1'b0);
        chk(irq_o == 1'b0, "R9", irq_o, 0);
        cfg_write(8'd1, 1'b1);
        chk(irq_o == 1'b1, "R9", irq_o, 1);
        irq_clear();
        chk(irq_o == 1'b0, "R8", irq_o, 0);
    endtask

    task automatic t_set_beats_clear();
        start_acc();
        repeat (255) @(negedge clk);
        irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
        chk(irq_o == 1'b1, "R8", irq_o, 1);
        repeat (2) @(negedge clk);
        irq_clear();
    endtask

    task automatic t_start_in_err();
        start_acc();
        repeat (256) @(negedge clk);
        chk(hresp_o && !hready_o, "R11", {hresp_o, hready_o}, 2'b10);
        start_acc();
        chk(hresp_o && hready_o, "R11", {hresp_o, hready_o}, 2'b11);
        @(negedge clk);
        chk(!hresp_o && hready_o, "R11", {hresp_o, hready_o}, 2'b01);
        @(negedge clk);
        chk(hready_o == 1'b1, "R11", hready_o, 1);
        irq_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_limit();
        t_short_limit();
        t_done_early();
        t_done_on_expiry();
        t_zero_off();
        t_mid_change();
        t_restart();
        t_irq_gate();
        t_set_beats_clear();
        t_start_in_err();
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule